// File: doc/BRIEF.md
# Programmable Spreading-Code Player

This block holds spreading codes as single bits in a 4096-entry memory and plays one code window out, one chip for each cycle in which the code-clock enable is high. A window is a start address and a length. An internal address counter walks upward from the start. After the programmed number of chips it returns to the start. The address arithmetic is modulo the memory depth, so a window may run past the top address and continue at address 0. Several codes can occupy the memory at once, and the active one is chosen by its window.

A host loads code bits and window settings through a plain address/data/write-enable port, and may do so while playback runs. New start and length values go into staging registers only. A separate commit write arms a switch, and the switch happens at the next code-period boundary. This allows a receiver to change from a short acquisition code to a long tracking code without breaking a period. The commit may also carry a small chip offset. The new window then begins that many chips into its period, and the receiver's one-direction search can pull the offset back into lock.

The chip output is a timed stream paced by the code-clock enable. It has no back-pressure: a chip is presented with a one-cycle valid strobe and must be taken then, because the code clock cannot wait. The host port is plain control and has no handshake. A write is always accepted in the cycle it is presented.

Top module: `spread_code_player`

## Requirements
- R1: During and after reset, `chip_out`, `chip_vld` and `epoch_out` are 0. The active window starts at address 0 with a length of 15 chips, and playback begins at position 0.
- R2: In the cycle after each cycle with `code_en` high, `chip_vld` is 1 and `chip_out` carries the memory bit at the current playback address. With `code_en` low, `chip_vld` is 0 in the next cycle, `chip_out` and `epoch_out` hold, and the playback position does not move.
- R3: Successive chips come from successive addresses, counted modulo 4096. After the chip at position length-1, the next chip comes from the window start again.
- R4: `epoch_out` is 1 together with every chip played from position 0 of a code period, and is 0 with every other chip.
- R5: A write with `host_sel`=0 stores `host_wdata[0]` at `host_addr`. Such a write is accepted while playback runs. A chip read in the same cycle as a write to its address returns the old bit, and later reads return the new bit.
- R6: A write with `host_sel`=1 stages a start address from `host_wdata[11:0]`. A write with `host_sel`=2 stages a length from `host_wdata[12:0]`. A staged length of 0 is ignored, and the previously staged length stays.
- R7: A write with `host_sel`=3 arms a switch and stages an offset from `host_wdata[3:0]`. At the enable that plays the last chip of the current period, the staged start and length become active. The next chip comes from address start+offset, at position offset of the new window. With offset 0 that chip carries `epoch_out`=1.
- R8: If the staged offset is not smaller than the staged length at the moment of the switch, the offset is taken as 0.
- R9: Staged start and length values have no effect on playback until a commit has been followed by a period boundary. Without an armed switch, every period boundary returns to the active start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_en | input | 1 | Code-clock enable; one chip per high cycle |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 code bit, 1 start, 2 length, 3 commit with offset |
| host_addr | input | 12 | Memory address for code-bit writes |
| host_wdata | input | 13 | Write data: bit, start, length or offset by target |
| chip_out | output | 1 | Current chip |
| chip_vld | output | 1 | One-cycle strobe marking a newly played chip |
| epoch_out | output | 1 | Chip is the first of a code period |

## Verification
The bench uses the default parameters: a 12-bit address, a 4-bit offset and a reset window of 15 chips. The whole 4096-bit memory is loaded, so windows that cross from address 4095 to 0 can be checked directly. The length field is 13 bits, and a 4-bit offset can exceed short windows. This puts the length-1 window, the offset-too-large fallback and the ignored zero length in reach of short runs. The code enable is driven both continuously and with gaps, so held outputs and boundary switches are checked under both pacings.

// File: rtl/spread_code_pkg.sv
package spread_code_pkg;

  typedef enum logic [1:0] {
    HS_BIT    = 2'd0,
    HS_START  = 2'd1,
    HS_LEN    = 2'd2,
    HS_COMMIT = 2'd3
  } host_sel_e;

endpackage

// File: rtl/code_store.sv
module code_store #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;

  // storage: a read in the same cycle as a write sees the old bit
  always_ff @(posedge clk) begin
    if (wr_en) bits_q[wr_addr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_bit <= 1'b0;
    else if (rd_en) rd_bit <= bits_q[rd_addr];
  end

endmodule

// File: rtl/code_window_ctrl.sv
module code_window_ctrl
  import spread_code_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = ADDR_W + 1,
  parameter int OFF_W     = 4,
  parameter int RST_START = 0,
  parameter int RST_LEN   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [LEN_W-1:0]  host_wdata,
  input  logic              wrap,
  output logic [ADDR_W-1:0] act_start,
  output logic [LEN_W-1:0]  act_len,
  output logic              take,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [LEN_W-1:0]  nxt_pos
);
  localparam int PAD_W = LEN_W - OFF_W;

  logic [ADDR_W-1:0] stg_start;
  logic [LEN_W-1:0]  stg_len;
  logic [OFF_W-1:0]  stg_off;
  logic              armed;
  logic              wr_start, wr_len, wr_commit;
  logic [LEN_W-1:0]  off_ext;

  assign wr_start  = host_we && (host_sel == HS_START);
  assign wr_len    = host_we && (host_sel == HS_LEN);
  assign wr_commit = host_we && (host_sel == HS_COMMIT);

  assign take    = wrap && armed;
  assign off_ext = {{PAD_W{1'b0}}, stg_off};
  assign nxt_pos = (off_ext < stg_len) ? off_ext : '0;
  assign nxt_addr = stg_start + nxt_pos[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_start <= ADDR_W'(RST_START);
      act_len   <= LEN_W'(RST_LEN);
      stg_start <= ADDR_W'(RST_START);
      stg_len   <= LEN_W'(RST_LEN);
      stg_off   <= '0;
      armed     <= 1'b0;
    end else begin
      if (take) begin
        act_start <= stg_start;
        act_len   <= stg_len;
      end
      if (wr_start) stg_start <= host_wdata[ADDR_W-1:0];
      if (wr_len && (host_wdata != '0)) stg_len <= host_wdata;
      if (wr_commit) begin
        armed   <= 1'b1;
        stg_off <= host_wdata[OFF_W-1:0];
      end else if (take) begin
        armed <= 1'b0;
      end
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act_len != '0); // R6

  AST_WINDOW_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_start) && $stable(act_len))); // R9

endmodule

// File: rtl/code_addr_seq.sv
module code_addr_seq #(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = ADDR_W + 1,
  parameter int RST_START = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_en,
  input  logic [ADDR_W-1:0] act_start,
  input  logic [LEN_W-1:0]  act_len,
  input  logic              take,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [LEN_W-1:0]  nxt_pos,
  output logic [ADDR_W-1:0] addr,
  output logic              last,
  output logic              first
);
  logic [LEN_W-1:0] pos;

  assign last  = (pos == act_len - 1'b1);
  assign first = (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      addr <= ADDR_W'(RST_START);
    end else if (code_en) begin
      if (last) begin
        if (take) begin
          pos  <= nxt_pos;
          addr <= nxt_addr;
        end else begin
          pos  <= '0;
          addr <= act_start;
        end
      end else begin
        pos  <= pos + 1'b1;
        addr <= addr + 1'b1;
      end
    end
  end

  AST_POS_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    pos < act_len); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_en && !last) |=> (addr == $past(addr) + 1'b1)); // R3

  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !code_en |=> ($stable(addr) && $stable(pos))); // R2

endmodule

// File: rtl/spread_code_player.sv
module spread_code_player #(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = ADDR_W + 1,
  parameter int OFF_W     = 4,
  parameter int RST_START = 0,
  parameter int RST_LEN   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_en,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [LEN_W-1:0]  host_wdata,
  output logic              chip_out,
  output logic              chip_vld,
  output logic              epoch_out
);
  logic [ADDR_W-1:0] act_start, nxt_addr, play_addr;
  logic [LEN_W-1:0]  act_len, nxt_pos;
  logic              take, last, first, wrap, bit_we;

  assign wrap   = code_en && last;
  assign bit_we = host_we && (host_sel == 2'd0);

  code_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bit_we),
    .wr_addr (host_addr),
    .wr_bit  (host_wdata[0]),
    .rd_en   (code_en),
    .rd_addr (play_addr),
    .rd_bit  (chip_out)
  );

  code_window_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W),
    .RST_START(RST_START), .RST_LEN(RST_LEN)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .wrap       (wrap),
    .act_start  (act_start),
    .act_len    (act_len),
    .take       (take),
    .nxt_addr   (nxt_addr),
    .nxt_pos    (nxt_pos)
  );

  code_addr_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RST_START(RST_START)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_en   (code_en),
    .act_start (act_start),
    .act_len   (act_len),
    .take      (take),
    .nxt_addr  (nxt_addr),
    .nxt_pos   (nxt_pos),
    .addr      (play_addr),
    .last      (last),
    .first     (first)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_vld  <= 1'b0;
      epoch_out <= 1'b0;
    end else begin
      chip_vld <= code_en;
      if (code_en) epoch_out <= first;
    end
  end

  AST_EPOCH_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (code_en && first) |=> (epoch_out && chip_vld)); // R4

  AST_NO_EPOCH_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
    (code_en && !first) |=> !epoch_out); // R4

endmodule

// File: tb/tb_spread_code_player.sv
`timescale 1ns/1ps
module tb_spread_code_player;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        code_en = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [11:0] host_addr = '0;
  logic [12:0] host_wdata = '0;
  logic        chip_out, chip_vld, epoch_out;

  spread_code_player dut (
    .clk(clk), .rst_n(rst_n), .code_en(code_en), .host_we(host_we),
    .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .chip_out(chip_out), .chip_vld(chip_vld), .epoch_out(epoch_out)
  );

  always #10 clk = ~clk;

  int    nchk = 0, nerr = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  bit m_mem [DEPTH];
  int m_pos, m_addr, m_start, m_len, s_start, s_len, s_off;
  bit pend, e_chip, e_vld, e_epoch;

  function automatic bit pat(int a);
    return bit'(((a * 7) >> 2) ^ (a >> 6) ^ (a >> 10));
  endfunction

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_addr = 0; m_start = 0; m_len = 15;
      s_start = 0; s_len = 15; s_off = 0; pend = 0;
      e_chip = 0; e_vld = 0; e_epoch = 0;
    end else begin
      e_vld = code_en;
      if (code_en) begin
        e_chip  = m_mem[m_addr];
        e_epoch = (m_pos == 0);
        if (m_pos == m_len - 1) begin
          if (pend) begin
            int o;
            o = (s_off < s_len) ? s_off : 0;
            m_start = s_start; m_len = s_len; m_pos = o;
            m_addr = (s_start + o) % DEPTH; pend = 0;
          end else begin
            m_pos = 0; m_addr = m_start;
          end
        end else begin
          m_pos++; m_addr = (m_addr + 1) % DEPTH;
        end
      end
      if (host_we) begin
        case (host_sel)
          2'd0: m_mem[host_addr] = host_wdata[0];
          2'd1: s_start = int'(host_wdata[11:0]);
          2'd2: if (host_wdata != 0) s_len = int'(host_wdata);
          default: begin pend = 1; s_off = int'(host_wdata[3:0]); end
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(chip_vld == e_vld, tag, "chip_vld", chip_vld, e_vld);
      chk(chip_out == e_chip, tag, "chip_out", chip_out, e_chip);
      chk(epoch_out == e_epoch, tag, "epoch_out", epoch_out, e_epoch);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      code_en = (mode == 0) ? 1'b1 : ((i % 3) != 1);
      @(negedge clk);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input int a, input int d);
    host_we = 1'b1; host_sel = sel; host_addr = 12'(a); host_wdata = 13'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    chk(chip_out == 1'b0 && chip_vld == 1'b0 && epoch_out == 1'b0, "R1", "reset outputs",
        {chip_out, chip_vld, epoch_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chip_vld == 1'b0 && epoch_out == 1'b0, "R1", "after reset", {chip_vld, epoch_out}, 0);

    tag = "R5";
    for (int a = 0; a < DEPTH; a++) hw(2'd0, a, int'(pat(a)));

    tag = "R3";
    run(40, 0);
    tag = "R2";
    run(45, 1);
    // R2: idle cycles hold the outputs and the position
    code_en = 1'b0;
    @(negedge clk);
    begin
      bit h_chip, h_ep;
      h_chip = chip_out; h_ep = epoch_out;
      repeat (4) @(negedge clk);
      chk(chip_out == h_chip && epoch_out == h_ep && !chip_vld, "R2", "hold while idle",
          {chip_out, epoch_out}, {h_chip, h_ep});
    end

    tag = "R5";
    code_en = 1'b1;
    for (int a = 0; a < 15; a++) hw(2'd0, a, int'(~pat(a)));
    run(30, 0);

    tag = "R9";
    hw(2'd1, 4090, 0);
    hw(2'd2, 0, 12);
    tag = "R6";
    hw(2'd2, 0, 0);
    run(45, 1);

    tag = "R7";
    hw(2'd3, 0, 0);
    run(40, 0);
    tag = "R3";
    run(30, 1);

    tag = "R7";
    hw(2'd1, 7, 0);
    hw(2'd2, 0, 1);
    hw(2'd3, 0, 0);
    run(20, 0);
    // length-1 window: every chip is address 7 and starts a period
    chk(chip_out == m_mem[7] && epoch_out == 1'b1 && chip_vld, "R7", "length one window",
        {chip_out, epoch_out}, {m_mem[7], 1'b1});
    run(1, 0);
    chk(chip_out == m_mem[7] && epoch_out == 1'b1, "R4", "epoch every chip", epoch_out, 1);

    hw(2'd1, 200, 0);
    hw(2'd2, 0, 20);
    hw(2'd3, 0, 3);
    run(60, 1);

    tag = "R8";
    hw(2'd1, 300, 0);
    hw(2'd2, 0, 4);
    hw(2'd3, 0, 9);
    run(40, 0);
    tag = "R6";
    hw(2'd1, 4000, 0);
    hw(2'd2, 0, 200);
    hw(2'd2, 0, 0);
    hw(2'd3, 0, 2);
    run(500, 1);

    code_en = 1'b0;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule